// File: doc/BRIEF.md
# Four-Phase Clocking-Zone Sequencer

This block produces the cyclic four-phase timing that drives pipelined ternary logic built from clocking zones. Each zone passes through switch, hold, release and relax, in that order, one phase per system clock edge while the run enable is high. Zone i lags the base zone (zone 0) by i phases. The lag makes a zone in hold the source for the next zone, which is in switch at that moment, and so data moves from lower-numbered zones to higher-numbered ones.

For every zone the block reports a two-bit phase code and a valid flag. The flag is high only while the zone is in hold. The block also gives an advance pulse that marks the zone's entry into switch, so downstream stages know when to take a new value. Clearing the run enable freezes every zone in its present phase. Reset puts the base zone in switch, which leaves only the last zone holding valid data at start.

Top module: `phase_zone_seq`

## Requirements
- R1: While reset is asserted, and after it until the first running edge, zone i shows phase (0 - i) mod 4. With the codes 00 = switch, 01 = hold, 10 = release, 11 = relax, phase_o reads zone0=00, zone1=11, zone2=10, zone3=01, valid_o = 4'b1000 and adv_o = 0.
- R2: Each clock edge with run_i high moves the base zone one step through the cycle 00, 01, 10, 11, 00.
- R3: At all times zone i's phase code equals the base zone's code minus i, modulo 4. Zone i occupies bits [2i+1:2i] of phase_o.
- R4: A clock edge with run_i low changes no phase code, and adv_o is all zero after that edge.
- R5: valid_o[i] is high exactly when zone i is in hold (code 01).
- R6: adv_o[i] is high for one cycle after a running edge that moved zone i from relax into switch. It is low at every other time.
- R7: At any time exactly one zone is valid.
- R8: When zone i (i < 3) is in hold, zone i+1 is in switch.
- R9: Under running edges, adv_o[i+1] pulses one running edge after adv_o[i]. adv_o[0] pulses again four running edges after its previous pulse, so a chain of the four zones spans one full phase cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run enable; low freezes all zones |
| phase_o | output | 8 | Phase code per zone, zone i at bits [2i+1:2i] |
| adv_o | output | 4 | Per-zone pulse on entry into switch |
| valid_o | output | 4 | Per-zone data-valid flag, high in hold |

## Verification
Phase codes and valid flags are registered state, so they are due in the cycle right after the edge that sampled run_i. The advance pulses come from a register loaded at that same edge, so they share that timing. The bench drives run_i at the falling edge and updates its reference model at the next rising edge. It compares every output at the following falling edge, one edge after the stimulus. Freeze runs, long run bursts and a reset in the middle of a run are mixed with random run_i patterns from a fixed seed.

// File: rtl/zseq_pkg.sv
package zseq_pkg;
  localparam int unsigned PHASE_W    = 2;
  localparam int unsigned NUM_PHASES = 4;

  typedef enum logic [PHASE_W-1:0] {
    PH_SWITCH  = 2'b00,
    PH_HOLD    = 2'b01,
    PH_RELEASE = 2'b10,
    PH_RELAX   = 2'b11
  } phase_e;

  function automatic phase_e next_phase(phase_e p);
    return phase_e'(PHASE_W'(p + 2'd1));
  endfunction

  function automatic phase_e lag_phase(phase_e base, int unsigned lag);
    logic [PHASE_W-1:0] d;
    d = PHASE_W'(lag % NUM_PHASES);
    return phase_e'(PHASE_W'(base - d));
  endfunction
endpackage

// File: rtl/base_phase_ctr.sv
module base_phase_ctr
  import zseq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  output phase_e base_o
);
  phase_e base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    base_q <= PH_SWITCH;
    else if (run_i) base_q <= next_phase(base_q);
  end

  assign base_o = base_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (base_q == phase_e'(PHASE_W'($past(base_q) + 2'd1))));
  p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(base_q));
endmodule

// File: rtl/zone_phase_map.sv
module zone_phase_map
  import zseq_pkg::*;
#(
  parameter int unsigned NUM_ZONES = 4
) (
  input  phase_e                            base_i,
  output logic [NUM_ZONES-1:0][PHASE_W-1:0] zone_o
);
  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    assign zone_o[z] = lag_phase(base_i, z);
  end
endmodule

// File: rtl/zone_event_gen.sv
module zone_event_gen
  import zseq_pkg::*;
#(
  parameter int unsigned NUM_ZONES = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              run_i,
  input  logic [NUM_ZONES-1:0][PHASE_W-1:0] zone_i,
  output logic [NUM_ZONES-1:0]              adv_o,
  output logic [NUM_ZONES-1:0]              valid_o
);
  logic [NUM_ZONES-1:0] adv_q;

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_evt
    // relax is the last phase before switch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) adv_q[z] <= 1'b0;
      else         adv_q[z] <= run_i && (zone_i[z] == PH_RELAX);
    end

    assign valid_o[z] = (zone_i[z] == PH_HOLD);

    p_adv_in_switch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_q[z] |-> (zone_i[z] == PH_SWITCH));
    p_adv_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_q[z] |=> !adv_q[z]);
    p_adv_needs_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !adv_q[z]);
  end

  assign adv_o = adv_q;
endmodule

// File: rtl/phase_zone_seq.sv
module phase_zone_seq
  import zseq_pkg::*;
#(
  parameter int unsigned NUM_ZONES = 4,
  localparam int unsigned PW       = NUM_ZONES * PHASE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  output logic [PW-1:0]        phase_o,
  output logic [NUM_ZONES-1:0] adv_o,
  output logic [NUM_ZONES-1:0] valid_o
);
  phase_e                            base;
  logic [NUM_ZONES-1:0][PHASE_W-1:0] zone;

  base_phase_ctr u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .base_o (base)
  );

  zone_phase_map #(.NUM_ZONES(NUM_ZONES)) u_map (
    .base_i (base),
    .zone_o (zone)
  );

  zone_event_gen #(.NUM_ZONES(NUM_ZONES)) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .zone_i  (zone),
    .adv_o   (adv_o),
    .valid_o (valid_o)
  );

  assign phase_o = zone;

  for (genvar z = 0; z + 1 < NUM_ZONES; z++) begin : g_flow
    p_hold_feeds_switch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o[z] |-> (phase_o[(z+1)*PHASE_W +: PHASE_W] == PH_SWITCH));
    p_adv_chain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_o[z] && run_i) |=> adv_o[z+1]);
  end

  if (NUM_ZONES == NUM_PHASES) begin : g_one_valid
    p_one_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(valid_o));
  end
endmodule

// File: tb/sim_phase_zone_seq.sv
module sim_phase_zone_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] phase;
  logic [3:0] adv;
  logic [3:0] valid;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  int          base_m = 0;
  logic [3:0]  adv_m = '0;
  int          run_cnt = 0;
  int          last_adv [4];
  bit          prev_run = 1'b0;

  always #2 clk = ~clk;

  phase_zone_seq u0 (
    .clk_i (clk), .rst_ni (rst_n), .run_i (run),
    .phase_o (phase), .adv_o (adv), .valid_o (valid)
  );

  function automatic int exp_phase(int b, int z);
    return (b - z + 8) % 4;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int nv;
    nv = 0;
    for (int z = 0; z < 4; z++) begin
      int e;
      e = exp_phase(base_m, z);
      check(phase[2*z +: 2] == 2'(e), "R2/R3 phase", int'(phase[2*z +: 2]), e);
      check(valid[z] == (e == 1), "R5 valid", int'(valid[z]), int'(e == 1));
      check(adv[z] == adv_m[z], "R6 adv", int'(adv[z]), int'(adv_m[z]));
      if (!prev_run) check(adv[z] == 1'b0, "R4 no adv when frozen", int'(adv[z]), 0);
      if (valid[z]) nv++;
      if (z < 3 && valid[z])
        check(phase[2*(z+1) +: 2] == 2'b00, "R8 next zone in switch",
              int'(phase[2*(z+1) +: 2]), 0);
      if (adv[z]) begin
        if (z > 0 && last_adv[z-1] >= 0)
          check(run_cnt - last_adv[z-1] == 1, "R9 chain step", run_cnt - last_adv[z-1], 1);
        if (z == 0 && last_adv[0] >= 0)
          check(run_cnt - last_adv[0] == 4, "R9 full cycle", run_cnt - last_adv[0], 4);
        last_adv[z] = run_cnt;
      end
    end
    check(nv == 1, "R7 one valid", nv, 1);
  endtask

  task automatic step(bit r);
    run = r;
    @(posedge clk);
    #0.1;
    prev_run = r;
    if (r) begin
      base_m = (base_m + 1) % 4;
      run_cnt++;
      for (int z = 0; z < 4; z++) adv_m[z] = (exp_phase(base_m, z) == 0);
    end else begin
      adv_m = '0;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    run = 1'b1;
    base_m = 0;
    adv_m = '0;
    prev_run = 1'b0;
    for (int z = 0; z < 4; z++) last_adv[z] = -1;
    repeat (2) @(negedge clk);
    // R1: reset state, even with run high
    check(phase == 8'b01_10_11_00, "R1 reset phase", int'(phase), 8'b01_10_11_00);
    check(valid == 4'b1000, "R1 reset valid", int'(valid), 4'b1000);
    check(adv == 4'b0000, "R1 reset adv", int'(adv), 0);
    run = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    do_reset();
    for (int k = 0; k < 12; k++) step(1'b1);     // long run burst
    for (int k = 0; k < 5; k++) step(1'b0);      // freeze R4
    step(1'b1); step(1'b0); step(1'b1); step(1'b1); step(1'b0);
    for (int k = 0; k < 600; k++) step(($urandom % 4) != 0);
    for (int k = 0; k < 3; k++) step(1'b1);
    do_reset();                                  // reset in middle of a run
    for (int k = 0; k < 300; k++) step(($urandom % 2) != 0);
    for (int k = 0; k < 8; k++) step(1'b1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule